// File: doc/BRIEF.md
# MDIO Paged Register Bridge

This block is the device-side target behind a management (MDIO-style) register port. It answers one management device address and offers there a small window of 16-bit registers. Through that window a host selects a page, loads up to 64 bits of data, and issues a read or write command. The bridge turns the command into one access on a wide internal register bus that carries a page, an offset and 64-bit data.

The host polls the command register to see when the access is done. The read and write command bits stay set while the internal access is in flight and clear themselves when the internal side answers ready. After a read has completed, the host collects the 64-bit result in four 16-bit slices. Serial MDIO framing is handled upstream, so the bridge sees decoded strobes only. The wide register file lives downstream.

Top module: `mgmt_page_bridge`

## Requirements
- R1: Only management device address 0x1E is served. A write to any other device address changes no state. A read from any other device address returns 0x0000.
- R2: Offset 0x10 is the page register. A write stores the page number from bits 15:8 and the enable flag from bit 0. A read returns the page in bits 15:8, the enable flag in bit 0 and zero in bits 7:1.
- R3: Offset 0x11 is the command register. Writing bit 0 starts an internal write and writing bit 1 starts an internal read. If both bits are set, the read is performed. The internal offset is taken from bits 15:8 of the written value, and the page is captured from the page register when the command starts. From the cycle after the command write, `bus_req_o` is high and `bus_page_o`, `bus_addr_o` and `bus_we_o` stay constant until `bus_ready_i` is seen high.
- R4: A read of offset 0x11 returns the captured offset in bits 15:8, read-busy in bit 1, write-busy in bit 0 and zero in bits 7:2. The busy bit is set from the command write onward. It clears after the clock edge where `bus_req_o` and `bus_ready_i` are both high, and `bus_req_o` falls at that same edge.
- R5: Offsets 0x18, 0x19, 0x1A and 0x1B are read/write 16-bit slices of a 64-bit data latch, holding bits 15:0, 31:16, 47:32 and 63:48 respectively. An internal write drives the latch contents on `bus_wdata_o`.
- R6: When an internal read completes, `bus_rdata_i` is loaded into the data latch. This load takes priority over a host slice write in the same cycle.
- R7: A command written while the page enable flag is clear is ignored: no internal access starts, and the busy bits and the captured offset are unchanged.
- R8: A command written while an access is busy is dropped: the access in flight, its offset and the data latch are unaffected by it.
- R9: Reads of unmapped offsets (any offset other than 0x10, 0x11 and 0x18 to 0x1B) return 0x0000, and writes to them have no effect.
- R10: After reset the page, enable flag, captured offset, busy bits and data latch are all zero, and `bus_req_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mgmt_req_i | input | 1 | Management access strobe, one cycle per access |
| mgmt_we_i | input | 1 | 1 = write access, 0 = read access |
| mgmt_dev_i | input | 5 | Management device address |
| mgmt_reg_i | input | 5 | Management register offset |
| mgmt_wdata_i | input | 16 | Management write data |
| mgmt_rdata_o | output | 16 | Read data for the addressed register (combinational) |
| bus_req_o | output | 1 | Internal access request, held until ready |
| bus_we_o | output | 1 | Internal access direction, 1 = write |
| bus_page_o | output | 8 | Internal page |
| bus_addr_o | output | 8 | Internal register offset within the page |
| bus_wdata_o | output | 64 | Internal write data (data latch) |
| bus_rdata_i | input | 64 | Internal read data, valid with ready |
| bus_ready_i | input | 1 | Internal completion, sampled while request is high |

## Verification
The assertions assume that the internal side raises `bus_ready_i` only while `bus_req_o` is high, and that `bus_rdata_i` is valid in the cycle where ready is high. The bench's register-file model asserts ready only for an outstanding request, after a fixed two-cycle wait, and derives read data from the current page and offset. They also assume that the host issues at most one management access per cycle, with its address and data steady across the sampling edge. The bench drives every access on the falling edge as a single-cycle strobe and deasserts the strobe during idle stretches.

// File: rtl/mgmt_bridge_pkg.sv
package mgmt_bridge_pkg;

  localparam int MDEV_W = 5;
  localparam int MREG_W = 5;

  // window offsets; the data slices are consecutive from OFS_DATA0
  localparam logic [MREG_W-1:0] OFS_PAGE  = 5'h10;
  localparam logic [MREG_W-1:0] OFS_CMD   = 5'h11;
  localparam logic [MREG_W-1:0] OFS_DATA0 = 5'h18;

  // command bit positions
  localparam int CMD_WR_BIT = 0;
  localparam int CMD_RD_BIT = 1;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_READ  = 2'd2
  } acc_state_e;

endpackage

// File: rtl/mgmt_win_decode.sv
module mgmt_win_decode
  import mgmt_bridge_pkg::*;
#(
  parameter logic [MDEV_W-1:0] DEV_ADDR = 5'h1E,
  parameter int                NSLICE   = 4
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [MDEV_W-1:0] dev_i,
  input  logic [MREG_W-1:0] reg_i,
  output logic              sel_page_o,
  output logic              sel_cmd_o,
  output logic [NSLICE-1:0] sel_slice_o,
  output logic              wr_page_o,
  output logic              wr_cmd_o,
  output logic [NSLICE-1:0] wr_slice_o
);

  logic hit;
  logic wr_en;

  assign hit   = (dev_i == DEV_ADDR);
  assign wr_en = req_i && we_i;

  assign sel_page_o = hit && (reg_i == OFS_PAGE);
  assign sel_cmd_o  = hit && (reg_i == OFS_CMD);
  assign wr_page_o  = wr_en && sel_page_o;
  assign wr_cmd_o   = wr_en && sel_cmd_o;

  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    assign sel_slice_o[i] = hit && (reg_i == MREG_W'(OFS_DATA0 + i));
    assign wr_slice_o[i]  = wr_en && sel_slice_o[i];
  end

endmodule

// File: rtl/mgmt_page_cfg.sv
module mgmt_page_cfg #(
  parameter int WIN_W  = 16,
  parameter int PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WIN_W-1:0]  wdata_i,
  output logic [PAGE_W-1:0] page_o,
  output logic              en_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_o <= '0;
      en_o   <= 1'b0;
    end else if (wr_i) begin
      page_o <= wdata_i[8 +: PAGE_W];
      en_o   <= wdata_i[0];
    end
  end

endmodule

// File: rtl/mgmt_data_latch.sv
module mgmt_data_latch #(
  parameter int DATA_W  = 64,
  parameter int SLICE_W = 16,
  localparam int NSLICE = DATA_W / SLICE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NSLICE-1:0]  wr_slice_i,
  input  logic [SLICE_W-1:0] wdata_i,
  input  logic               load_i,
  input  logic [DATA_W-1:0]  rdata_i,
  output logic [DATA_W-1:0]  data_o
);

  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[i*SLICE_W +: SLICE_W] <= '0;
      end else if (load_i) begin
        // read result wins over a host slice write in the same cycle
        data_o[i*SLICE_W +: SLICE_W] <= rdata_i[i*SLICE_W +: SLICE_W];
      end else if (wr_slice_i[i]) begin
        data_o[i*SLICE_W +: SLICE_W] <= wdata_i;
      end
    end
  end

endmodule

// File: rtl/mgmt_access_seq.sv
module mgmt_access_seq
  import mgmt_bridge_pkg::*;
#(
  parameter int WIN_W  = 16,
  parameter int PAGE_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wr_i,
  input  logic [WIN_W-1:0]  wdata_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              page_en_i,
  input  logic              bus_ready_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [PAGE_W-1:0] bus_page_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              rd_busy_o,
  output logic              wr_busy_o,
  output logic              load_o
);

  acc_state_e state_q, state_d;
  logic [PAGE_W-1:0] page_q;
  logic [ADDR_W-1:0] addr_q;
  logic start, done, want_rd, want_wr;

  assign want_rd = wdata_i[CMD_RD_BIT];
  assign want_wr = wdata_i[CMD_WR_BIT];
  assign start   = cmd_wr_i && page_en_i && (state_q == ACC_IDLE) && (want_rd || want_wr);
  assign done    = (state_q != ACC_IDLE) && bus_ready_i;

  always_comb begin
    state_d = state_q;
    if (start) begin
      state_d = want_rd ? ACC_READ : ACC_WRITE;
    end else if (done) begin
      state_d = ACC_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ACC_IDLE;
      page_q  <= '0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (start) begin
        page_q <= page_i;
        addr_q <= wdata_i[8 +: ADDR_W];
      end
    end
  end

  assign bus_req_o  = (state_q != ACC_IDLE);
  assign bus_we_o   = (state_q == ACC_WRITE);
  assign bus_page_o = page_q;
  assign bus_addr_o = addr_q;
  assign rd_busy_o  = (state_q == ACC_READ);
  assign wr_busy_o  = (state_q == ACC_WRITE);
  assign load_o     = done && (state_q == ACC_READ);

endmodule

// File: rtl/mgmt_page_bridge.sv
module mgmt_page_bridge
  import mgmt_bridge_pkg::*;
#(
  parameter logic [4:0] DEV_ADDR = 5'h1E,
  parameter int         DATA_W   = 64,
  parameter int         WIN_W    = 16,
  parameter int         PAGE_W   = 8,
  parameter int         ADDR_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mgmt_req_i,
  input  logic              mgmt_we_i,
  input  logic [4:0]        mgmt_dev_i,
  input  logic [4:0]        mgmt_reg_i,
  input  logic [WIN_W-1:0]  mgmt_wdata_i,
  output logic [WIN_W-1:0]  mgmt_rdata_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [PAGE_W-1:0] bus_page_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_ready_i
);

  localparam int NSLICE = DATA_W / WIN_W;

  logic              sel_page, sel_cmd, wr_page, wr_cmd;
  logic [NSLICE-1:0] sel_slice, wr_slice;
  logic [PAGE_W-1:0] page_q;
  logic              page_en;
  logic              rd_busy, wr_busy, load;
  logic [DATA_W-1:0] data_q;
  logic [WIN_W-1:0]  page_rb, cmd_rb;

  mgmt_win_decode #(
    .DEV_ADDR (DEV_ADDR),
    .NSLICE   (NSLICE)
  ) u_decode (
    .req_i       (mgmt_req_i),
    .we_i        (mgmt_we_i),
    .dev_i       (mgmt_dev_i),
    .reg_i       (mgmt_reg_i),
    .sel_page_o  (sel_page),
    .sel_cmd_o   (sel_cmd),
    .sel_slice_o (sel_slice),
    .wr_page_o   (wr_page),
    .wr_cmd_o    (wr_cmd),
    .wr_slice_o  (wr_slice)
  );

  mgmt_page_cfg #(
    .WIN_W  (WIN_W),
    .PAGE_W (PAGE_W)
  ) u_page (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_page),
    .wdata_i (mgmt_wdata_i),
    .page_o  (page_q),
    .en_o    (page_en)
  );

  mgmt_access_seq #(
    .WIN_W  (WIN_W),
    .PAGE_W (PAGE_W),
    .ADDR_W (ADDR_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_wr_i    (wr_cmd),
    .wdata_i     (mgmt_wdata_i),
    .page_i      (page_q),
    .page_en_i   (page_en),
    .bus_ready_i (bus_ready_i),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_page_o  (bus_page_o),
    .bus_addr_o  (bus_addr_o),
    .rd_busy_o   (rd_busy),
    .wr_busy_o   (wr_busy),
    .load_o      (load)
  );

  mgmt_data_latch #(
    .DATA_W  (DATA_W),
    .SLICE_W (WIN_W)
  ) u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_slice_i (wr_slice),
    .wdata_i    (mgmt_wdata_i),
    .load_i     (load),
    .rdata_i    (bus_rdata_i),
    .data_o     (data_q)
  );

  assign bus_wdata_o = data_q;

  always_comb begin
    page_rb = '0;
    page_rb[8 +: PAGE_W] = page_q;
    page_rb[0] = page_en;
    cmd_rb = '0;
    cmd_rb[8 +: ADDR_W] = bus_addr_o;
    cmd_rb[CMD_RD_BIT] = rd_busy;
    cmd_rb[CMD_WR_BIT] = wr_busy;
  end

  always_comb begin
    mgmt_rdata_o = '0;
    if (sel_page) mgmt_rdata_o = page_rb;
    if (sel_cmd)  mgmt_rdata_o = cmd_rb;
    for (int i = 0; i < NSLICE; i++) begin
      if (sel_slice[i]) mgmt_rdata_o = data_q[i*WIN_W +: WIN_W];
    end
  end

endmodule

// File: rtl/mgmt_page_bridge_chk.sv
module mgmt_page_bridge_chk #(
  parameter logic [4:0] DEV_ADDR = 5'h1E,
  parameter int         DATA_W   = 64,
  parameter int         WIN_W    = 16,
  parameter int         PAGE_W   = 8,
  parameter int         ADDR_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [4:0]        mgmt_dev_i,
  input logic [WIN_W-1:0]  mgmt_rdata_o,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [PAGE_W-1:0] bus_page_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_rdata_i,
  input logic              bus_ready_i,
  input logic              page_en_i,
  input logic [DATA_W-1:0] latch_i
);

  assert_foreign_dev_silent_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mgmt_dev_i != DEV_ADDR) |-> (mgmt_rdata_o == '0));

  assert_request_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ready_i) |=>
      (bus_req_o && $stable(bus_we_o) && $stable(bus_page_o) && $stable(bus_addr_o)));

  assert_done_clears_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_ready_i) |=> !bus_req_o);

  assert_read_loads_latch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_ready_i && !bus_we_o) |=> (latch_i == $past(bus_rdata_i)));

  assert_start_needs_enable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) |-> $past(page_en_i));

endmodule

bind mgmt_page_bridge mgmt_page_bridge_chk #(
  .DEV_ADDR (DEV_ADDR),
  .DATA_W   (DATA_W),
  .WIN_W    (WIN_W),
  .PAGE_W   (PAGE_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mgmt_dev_i   (mgmt_dev_i),
  .mgmt_rdata_o (mgmt_rdata_o),
  .bus_req_o    (bus_req_o),
  .bus_we_o     (bus_we_o),
  .bus_page_o   (bus_page_o),
  .bus_addr_o   (bus_addr_o),
  .bus_rdata_i  (bus_rdata_i),
  .bus_ready_i  (bus_ready_i),
  .page_en_i    (page_en),
  .latch_i      (data_q)
);

// File: tb/mgmt_page_bridge_tb.sv
`timescale 1ns/1ps
module mgmt_page_bridge_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mgmt_req_i = 1'b0, mgmt_we_i = 1'b0;
  logic [4:0]  mgmt_dev_i = '0, mgmt_reg_i = '0;
  logic [15:0] mgmt_wdata_i = '0;
  logic [15:0] mgmt_rdata_o;
  logic        bus_req_o, bus_we_o, bus_ready_i;
  logic [7:0]  bus_page_o, bus_addr_o;
  logic [63:0] bus_wdata_o, bus_rdata_i;

  int checks = 0;
  int fails  = 0;

  always #4 clk_i = ~clk_i;

  mgmt_page_bridge u_dut (
    .clk_i, .rst_ni, .mgmt_req_i, .mgmt_we_i, .mgmt_dev_i, .mgmt_reg_i,
    .mgmt_wdata_i, .mgmt_rdata_o, .bus_req_o, .bus_we_o, .bus_page_o,
    .bus_addr_o, .bus_wdata_o, .bus_rdata_i, .bus_ready_i
  );

  // internal register file model: 16 entries, ready after two wait cycles
  logic [63:0] mem [16];
  logic [3:0]  mem_idx;
  int unsigned lat_cnt;
  assign mem_idx     = {bus_page_o[1:0], bus_addr_o[1:0]};
  assign bus_ready_i = bus_req_o && (lat_cnt == 2);
  assign bus_rdata_i = mem[mem_idx];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_cnt <= 0;
      for (int i = 0; i < 16; i++) mem[i] <= '0;
    end else if (bus_req_o && bus_ready_i) begin
      lat_cnt <= 0;
      if (bus_we_o) mem[mem_idx] <= bus_wdata_o;
    end else if (bus_req_o) begin
      lat_cnt <= lat_cnt + 1;
    end
  end

  // vector: [31:28] requirement, [27:26] kind (0 wr, 1 rd-check, 2 idle), [25:21] dev, [20:16] reg, [15:0] data
  localparam int NVEC = 58;
  localparam logic [31:0] VEC [NVEC] = '{
    {4'd2, 2'd0, 5'h1E, 5'h10, 16'h0301},  // R2 page 3, enabled
    {4'd2, 2'd1, 5'h1E, 5'h10, 16'h0301},  // R2
    {4'd5, 2'd0, 5'h1E, 5'h18, 16'h1111},  // R5
    {4'd5, 2'd0, 5'h1E, 5'h19, 16'h2222},
    {4'd5, 2'd0, 5'h1E, 5'h1A, 16'h3333},
    {4'd5, 2'd0, 5'h1E, 5'h1B, 16'h4444},
    {4'd5, 2'd1, 5'h1E, 5'h1A, 16'h3333},  // R5
    {4'd3, 2'd0, 5'h1E, 5'h11, 16'h0501},  // R3 write to offset 5
    {4'd4, 2'd1, 5'h1E, 5'h11, 16'h0501},  // R4 busy visible
    {4'd4, 2'd2, 5'h1E, 5'h00, 16'd6},
    {4'd4, 2'd1, 5'h1E, 5'h11, 16'h0500},  // R4 busy cleared
    {4'd6, 2'd0, 5'h1E, 5'h18, 16'h0000},
    {4'd6, 2'd0, 5'h1E, 5'h19, 16'h0000},
    {4'd6, 2'd0, 5'h1E, 5'h1A, 16'h0000},
    {4'd6, 2'd0, 5'h1E, 5'h1B, 16'h0000},
    {4'd6, 2'd0, 5'h1E, 5'h11, 16'h0502},  // R6 read back offset 5
    {4'd6, 2'd2, 5'h1E, 5'h00, 16'd6},
    {4'd6, 2'd1, 5'h1E, 5'h18, 16'h1111},  // R6
    {4'd6, 2'd1, 5'h1E, 5'h19, 16'h2222},
    {4'd6, 2'd1, 5'h1E, 5'h1A, 16'h3333},
    {4'd6, 2'd1, 5'h1E, 5'h1B, 16'h4444},
    {4'd1, 2'd0, 5'h1D, 5'h10, 16'h0001},  // R1 foreign device write
    {4'd1, 2'd1, 5'h1E, 5'h10, 16'h0301},  // R1 page untouched
    {4'd1, 2'd1, 5'h1D, 5'h10, 16'h0000},  // R1 foreign device reads zero
    {4'd9, 2'd0, 5'h1E, 5'h12, 16'hBEEF},  // R9
    {4'd9, 2'd1, 5'h1E, 5'h12, 16'h0000},
    {4'd9, 2'd1, 5'h1E, 5'h15, 16'h0000},
    {4'd9, 2'd1, 5'h1E, 5'h1C, 16'h0000},
    {4'd7, 2'd0, 5'h1E, 5'h10, 16'h0300},  // R7 disable page
    {4'd7, 2'd0, 5'h1E, 5'h11, 16'h0702},
    {4'd7, 2'd2, 5'h1E, 5'h00, 16'd3},
    {4'd7, 2'd1, 5'h1E, 5'h11, 16'h0500},  // R7 ignored
    {4'd2, 2'd1, 5'h1E, 5'h10, 16'h0300},  // R2
    {4'd8, 2'd0, 5'h1E, 5'h10, 16'h0301},
    {4'd8, 2'd0, 5'h1E, 5'h18, 16'hAAAA},
    {4'd8, 2'd0, 5'h1E, 5'h19, 16'hBBBB},
    {4'd8, 2'd0, 5'h1E, 5'h1A, 16'hCCCC},
    {4'd8, 2'd0, 5'h1E, 5'h1B, 16'hDDDD},
    {4'd8, 2'd0, 5'h1E, 5'h11, 16'h0601},  // R8 write offset 6
    {4'd8, 2'd0, 5'h1E, 5'h11, 16'h0502},  // R8 dropped
    {4'd8, 2'd2, 5'h1E, 5'h00, 16'd6},
    {4'd8, 2'd1, 5'h1E, 5'h11, 16'h0600},  // R8
    {4'd8, 2'd1, 5'h1E, 5'h18, 16'hAAAA},  // R8 latch not reloaded
    {4'd6, 2'd0, 5'h1E, 5'h18, 16'h0000},
    {4'd6, 2'd0, 5'h1E, 5'h11, 16'h0602},
    {4'd6, 2'd2, 5'h1E, 5'h00, 16'd6},
    {4'd6, 2'd1, 5'h1E, 5'h18, 16'hAAAA},  // R6
    {4'd5, 2'd1, 5'h1E, 5'h1B, 16'hDDDD},  // R5
    {4'd3, 2'd0, 5'h1E, 5'h10, 16'h0101},  // R3 page 1
    {4'd3, 2'd0, 5'h1E, 5'h11, 16'h0502},
    {4'd3, 2'd2, 5'h1E, 5'h00, 16'd6},
    {4'd3, 2'd1, 5'h1E, 5'h18, 16'h0000},  // R3 page selects entry
    {4'd3, 2'd0, 5'h1E, 5'h10, 16'h0301},
    {4'd3, 2'd0, 5'h1E, 5'h18, 16'h5A5A},
    {4'd3, 2'd0, 5'h1E, 5'h11, 16'h0603},  // R3 both bits: read
    {4'd3, 2'd2, 5'h1E, 5'h00, 16'd6},
    {4'd3, 2'd1, 5'h1E, 5'h18, 16'hAAAA},
    {4'd3, 2'd1, 5'h1E, 5'h11, 16'h0600}
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic mgmt_wr(logic [4:0] dev, logic [4:0] rg, logic [15:0] d);
    @(negedge clk_i);
    mgmt_req_i = 1'b1; mgmt_we_i = 1'b1;
    mgmt_dev_i = dev; mgmt_reg_i = rg; mgmt_wdata_i = d;
  endtask

  task automatic mgmt_rd(logic [4:0] dev, logic [4:0] rg, output logic [15:0] d);
    @(negedge clk_i);
    mgmt_req_i = 1'b1; mgmt_we_i = 1'b0;
    mgmt_dev_i = dev; mgmt_reg_i = rg;
    #1 d = mgmt_rdata_o;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      mgmt_req_i = 1'b0; mgmt_we_i = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] e;
      e = VEC[v];
      case (e[27:26])
        2'd0: mgmt_wr(e[25:21], e[20:16], e[15:0]);
        2'd1: begin
          mgmt_rd(e[25:21], e[20:16], rd);
          check($sformatf("R%0d vec %0d", e[31:28], v), 64'(rd), 64'(e[15:0]));
        end
        default: idle(int'(e[15:0]));
      endcase
    end
    idle(2);

    // R3 R5: internal bus fields during a write access
    mgmt_wr(5'h1E, 5'h10, 16'h0201);
    mgmt_wr(5'h1E, 5'h18, 16'h1234);
    mgmt_wr(5'h1E, 5'h11, 16'h0901);
    idle(1);
    #1;
    check("R3 bus_req", 64'(bus_req_o), 64'd1);
    check("R3 bus_we", 64'(bus_we_o), 64'd1);
    check("R3 bus_page", 64'(bus_page_o), 64'h02);
    check("R3 bus_addr", 64'(bus_addr_o), 64'h09);
    check("R5 bus_wdata", 64'(bus_wdata_o[15:0]), 64'h1234);
    idle(6);
    #1;
    check("R4 req released", 64'(bus_req_o), 64'd0);
    check("R5 stored entry", mem[9][15:0], 64'h1234);

    // R10: reset returns everything to zero
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1 check("R10 bus_req", 64'(bus_req_o), 64'd0);
    mgmt_rd(5'h1E, 5'h10, rd);
    check("R10 page reg", 64'(rd), 64'h0);
    mgmt_rd(5'h1E, 5'h11, rd);
    check("R10 cmd reg", 64'(rd), 64'h0);
    mgmt_rd(5'h1E, 5'h18, rd);
    check("R10 data slice", 64'(rd), 64'h0);
    idle(1);

    finish_run();
  end

endmodule